// File: doc/BRIEF.md
# Direct-Mode Wired Interrupt Controller

This block collects a parameterised set of wired interrupt sources, numbered 1 to `NUM_SRC`, and drives one external interrupt line per hart. Each source has a trigger mode and a target that names exactly one hart and a priority. Software enables sources by number, either one at a time or 32 at a time. Each hart sees the best eligible source routed to it through its own delivery window, which holds a delivery enable, a priority threshold, a non-destructive top register and a claim register.

A claim read returns the winning source and clears its pending state in the same access. A service routine therefore reads claim in a loop until it returns zero, and the hart's line falls once nothing eligible remains. The register port carries 32-bit words. A write takes effect at the clock edge where `reg_wr_i` is high. A read issued with `reg_rd_i` returns its data on `reg_rdata_o` one cycle later, flagged by `reg_rvalid_o`. The port never stalls, so it has no back-pressure. Source inputs pass through a two-flop synchroniser, and a pending bit follows an input change by three clock edges.

Top module: `wired_irq_ctrl`

## Requirements
- R1: After reset the domain register reads 0, every `irq_o` bit is low, every claim reads 0, and every target reads 0 (hart 0, priority 0).
- R2: The mode field is bits 2:0 of the configuration word at byte address 0x0004+4*(s-1). The codes are 0 inactive, 1 rising edge, 2 falling edge, 3 level high and 4 level low. A write of codes 5 to 7 stores 0. An inactive source never becomes pending.
- R3: An edge-mode source becomes pending on its selected edge of `src_irq_i[s-1]`. It stays pending, whether or not it is enabled, until it is claimed.
- R4: A level-mode source is pending while its input is at the active level. It pends again after a claim if the input is still active. It stops pending when the input goes inactive.
- R5: Writing s to 0x1080 enables source s, and writing s to 0x1084 disables it. Values 0 and values above `NUM_SRC` change nothing.
- R6: A write to the clear word at 0x1000+4*k disables source 32*k+b for every set bit b of the data.
- R7: The target word at 0x2004+4*(s-1) holds the hart index in bits 18 and up and the priority in its low `PRIO_W` bits. A source is reported and delivered only to the hart named there.
- R8: A lower priority value wins, and a priority of 0 counts as 1. On equal priority the lower source number wins.
- R9: The threshold lives at 0x4004+32*h. When it is nonzero, only sources with a priority below it are eligible. A threshold of 0 admits every source.
- R10: Claim (0x400C+32*h) and top (0x4008+32*h) both return the source number in bits 25:16 and the effective priority in the low bits. Claim clears that source's pending bit; top does not. Every read produces `reg_rvalid_o` in the next cycle.
- R11: The domain register at 0x0000 has an interrupt-enable bit in bit 0. While that bit is 0, every `irq_o` bit is low. The message-mode bit (bit 2) always reads 0.
- R12: The delivery enable at 0x4000+32*h, bit 0, gates `irq_o[h]` without changing what top reports.
- R13: Reads of unmapped addresses return 0. This covers absent harts, unused window offsets and sources above `NUM_SRC`.
- R14: `irq_o[h]` is high exactly when the domain enable, the hart's delivery enable and an eligible source are all present. It falls after the claim that removes the last eligible source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_irq_i | input | NUM_SRC | Wired sources; bit s-1 is source s |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 16 | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| irq_o | output | NUM_HART | External interrupt line per hart |

## Verification
The bench targets the corners where a wrong controller would still look healthy at first glance. A priority 0 that is not promoted to 1 would make source 9 beat source 10 on the priority value, not on the tie rule. A claim that failed to clear would loop forever on the same edge source. A level source that is cleared for good would never come back after its claim. Enable-by-number values of 0 and `NUM_SRC`+1 must not alias onto real sources. A bulk clear of the second word must spare source 2. The bench also checks that a threshold equal to the priority blocks the source, and that both the domain gate and the delivery gate drop the line while top still reports the source.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam int ID_W     = 10;
  localparam int ID_LSB   = 16;
  localparam int HART_LSB = 18;
  localparam int ADDR_W   = 16;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_RISE = 3'd1,
    MODE_FALL = 3'd2,
    MODE_HIGH = 3'd3,
    MODE_LOW  = 3'd4
  } trig_mode_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DOM, SEL_CFG, SEL_TGT, SEL_BANK, SEL_SETNUM,
    SEL_CLRNUM, SEL_DELIV, SEL_THRESH, SEL_TOP, SEL_CLAIM
  } reg_sel_e;
endpackage

// File: rtl/wic_addr_decode.sv
module wic_addr_decode
  import wic_pkg::*;
#(
  parameter int NUM_SRC  = 40,
  parameter int NUM_HART = 2,
  localparam int HART_W  = (NUM_HART > 1) ? $clog2(NUM_HART) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [ID_W-1:0]   idx_o,
  output logic [HART_W-1:0] hart_o,
  output logic [4:0]        word_o
);
  logic [3:0]      region;
  logic [ID_W-1:0] widx;
  logic [6:0]      hart_n;
  logic [2:0]      ireg;

  assign region = addr_i[15:12];
  assign widx   = addr_i[11:2];
  assign hart_n = addr_i[11:5];
  assign ireg   = addr_i[4:2];
  assign idx_o  = widx;
  assign word_o = addr_i[6:2];
  assign hart_o = hart_n[HART_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      unique case (region)
        4'h0: begin
          if (widx == '0) sel_o = SEL_DOM;
          else if (widx <= ID_W'(NUM_SRC)) sel_o = SEL_CFG;
        end
        4'h1: begin
          if (addr_i[11:7] == 5'd0 && addr_i[6:2] <= 5'(NUM_SRC / 32)) sel_o = SEL_BANK;
          else if (widx == 10'h020) sel_o = SEL_SETNUM;
          else if (widx == 10'h021) sel_o = SEL_CLRNUM;
        end
        4'h2: begin
          if (widx != '0 && widx <= ID_W'(NUM_SRC)) sel_o = SEL_TGT;
        end
        4'h4: begin
          if (hart_n < 7'(NUM_HART)) begin
            case (ireg)
              3'd0: sel_o = SEL_DELIV;
              3'd1: sel_o = SEL_THRESH;
              3'd2: sel_o = SEL_TOP;
              3'd3: sel_o = SEL_CLAIM;
              default: sel_o = SEL_NONE;
            endcase
          end
        end
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wic_source.sv
module wic_source
  import wic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       raw_i,
  input  trig_mode_e mode_i,
  input  logic       cfg_wr_i,
  input  logic       claim_i,
  output logic       pend_o
);
  logic s1_q, s2_q, prev_q, pend_d;

  always_comb begin
    case (mode_i)
      MODE_RISE: pend_d = (s2_q & ~prev_q) | (pend_o & ~claim_i);
      MODE_FALL: pend_d = (~s2_q & prev_q) | (pend_o & ~claim_i);
      MODE_HIGH: pend_d = s2_q & ~claim_i;
      MODE_LOW:  pend_d = ~s2_q & ~claim_i;
      default:   pend_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      pend_o <= cfg_wr_i ? 1'b0 : pend_d;
    end
  end
endmodule

// File: rtl/wic_hart_pick.sv
module wic_hart_pick
  import wic_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 8,
  parameter int HART_W  = 1,
  parameter int HART_ID = 0
) (
  input  logic [NUM_SRC-1:0]        live_i,
  input  logic [NUM_SRC*HART_W-1:0] hart_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thresh_i,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [PRIO_W-1:0] p;
  logic              ok;
  logic              found;

  always_comb begin
    id_o   = '0;
    prio_o = '0;
    found  = 1'b0;
    p      = '0;
    ok     = 1'b0;
    for (int j = 0; j < NUM_SRC; j++) begin
      p = prio_i[j*PRIO_W +: PRIO_W];
      if (p == '0) p = PRIO_W'(1);
      ok = live_i[j] && (hart_i[j*HART_W +: HART_W] == HART_W'(HART_ID))
           && (thresh_i == '0 || p < thresh_i);
      if (ok && (!found || p < prio_o)) begin
        found  = 1'b1;
        id_o   = ID_W'(j + 1);
        prio_o = p;
      end
    end
  end
endmodule

// File: rtl/wired_irq_ctrl.sv
module wired_irq_ctrl
  import wic_pkg::*;
#(
  parameter int NUM_SRC  = 40,
  parameter int NUM_HART = 2,
  parameter int PRIO_W   = 8,
  localparam int HART_W  = (NUM_HART > 1) ? $clog2(NUM_HART) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_irq_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                reg_rvalid_o,
  output logic [NUM_HART-1:0] irq_o
);
  reg_sel_e          sel;
  logic [ID_W-1:0]   dec_idx;
  logic [HART_W-1:0] dec_hart;
  logic [4:0]        dec_word;

  logic                      dom_ie_q;
  trig_mode_e                cfg_q [NUM_SRC];
  logic [NUM_SRC*HART_W-1:0] tgt_hart_q;
  logic [NUM_SRC*PRIO_W-1:0] tgt_prio_q;
  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_HART-1:0]       deliv_q;
  logic [PRIO_W-1:0]         thresh_q [NUM_HART];

  logic [NUM_SRC-1:0]  pend, src_off, claim_clr;
  logic [NUM_HART-1:0] claim_hit, top_nz;
  logic [ID_W-1:0]     top_id   [NUM_HART];
  logic [PRIO_W-1:0]   top_prio [NUM_HART];
  logic [31:0]         hart_word [NUM_HART];
  logic [31:0]         rd_mux;

  wic_addr_decode #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART)) u_dec (
    .addr_i(reg_addr_i), .sel_o(sel), .idx_o(dec_idx), .hart_o(dec_hart), .word_o(dec_word)
  );

  // Per-source trigger and pending logic
  for (genvar j = 0; j < NUM_SRC; j++) begin : g_src
    logic cfg_wr;
    assign cfg_wr     = reg_wr_i && sel == SEL_CFG && dec_idx == ID_W'(j + 1);
    assign src_off[j] = (cfg_q[j] == MODE_OFF);
    wic_source u_src (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(src_irq_i[j]), .mode_i(cfg_q[j]),
      .cfg_wr_i(cfg_wr), .claim_i(claim_clr[j]), .pend_o(pend[j])
    );
  end

  // Per-hart selection of the best eligible source
  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    wic_hart_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .HART_W(HART_W), .HART_ID(h)) u_pick (
      .live_i(pend & en_q), .hart_i(tgt_hart_q), .prio_i(tgt_prio_q),
      .thresh_i(thresh_q[h]), .id_o(top_id[h]), .prio_o(top_prio[h])
    );
    assign top_nz[h]    = (top_id[h] != '0);
    assign claim_hit[h] = reg_rd_i && sel == SEL_CLAIM && dec_hart == HART_W'(h);
    assign irq_o[h]     = dom_ie_q && deliv_q[h] && top_nz[h];
    always_comb begin
      hart_word[h] = '0;
      hart_word[h][ID_LSB +: ID_W] = top_id[h];
      hart_word[h][PRIO_W-1:0]     = top_prio[h];
    end
  end

  always_comb begin
    claim_clr = '0;
    for (int j = 0; j < NUM_SRC; j++)
      for (int h = 0; h < NUM_HART; h++)
        if (claim_hit[h] && top_id[h] == ID_W'(j + 1)) claim_clr[j] = 1'b1;
  end

  // Source configuration and target registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dom_ie_q   <= 1'b0;
      tgt_hart_q <= '0;
      tgt_prio_q <= '0;
      for (int j = 0; j < NUM_SRC; j++) cfg_q[j] <= MODE_OFF;
    end else if (reg_wr_i) begin
      if (sel == SEL_DOM) dom_ie_q <= reg_wdata_i[0];
      for (int j = 0; j < NUM_SRC; j++) begin
        if (dec_idx == ID_W'(j + 1)) begin
          if (sel == SEL_CFG)
            cfg_q[j] <= (reg_wdata_i[2:0] <= 3'd4) ? trig_mode_e'(reg_wdata_i[2:0]) : MODE_OFF;
          if (sel == SEL_TGT) begin
            tgt_hart_q[j*HART_W +: HART_W] <= reg_wdata_i[HART_LSB +: HART_W];
            tgt_prio_q[j*PRIO_W +: PRIO_W] <= reg_wdata_i[PRIO_W-1:0];
          end
        end
      end
    end
  end

  // Enable bits: by number and by 32-bit clear words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (reg_wr_i) begin
      for (int j = 0; j < NUM_SRC; j++) begin
        if (sel == SEL_SETNUM && reg_wdata_i == 32'(j + 1)) en_q[j] <= 1'b1;
        if (sel == SEL_CLRNUM && reg_wdata_i == 32'(j + 1)) en_q[j] <= 1'b0;
        if (sel == SEL_BANK && dec_word == 5'((j + 1) / 32) && reg_wdata_i[(j + 1) % 32])
          en_q[j] <= 1'b0;
      end
    end
  end

  // Per-hart delivery control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliv_q <= '0;
      for (int h = 0; h < NUM_HART; h++) thresh_q[h] <= '0;
    end else if (reg_wr_i) begin
      for (int h = 0; h < NUM_HART; h++) begin
        if (dec_hart == HART_W'(h)) begin
          if (sel == SEL_DELIV)  deliv_q[h]  <= reg_wdata_i[0];
          if (sel == SEL_THRESH) thresh_q[h] <= reg_wdata_i[PRIO_W-1:0];
        end
      end
    end
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DOM: rd_mux[0] = dom_ie_q;
      SEL_CFG, SEL_TGT: begin
        for (int j = 0; j < NUM_SRC; j++) begin
          if (dec_idx == ID_W'(j + 1)) begin
            if (sel == SEL_CFG) rd_mux[2:0] = cfg_q[j];
            else begin
              rd_mux[HART_LSB +: HART_W] = tgt_hart_q[j*HART_W +: HART_W];
              rd_mux[PRIO_W-1:0]         = tgt_prio_q[j*PRIO_W +: PRIO_W];
            end
          end
        end
      end
      SEL_DELIV, SEL_THRESH, SEL_TOP, SEL_CLAIM: begin
        for (int h = 0; h < NUM_HART; h++) begin
          if (dec_hart == HART_W'(h)) begin
            if (sel == SEL_DELIV)       rd_mux[0] = deliv_q[h];
            else if (sel == SEL_THRESH) rd_mux[PRIO_W-1:0] = thresh_q[h];
            else                        rd_mux = hart_word[h];
          end
        end
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
    end else begin
      reg_rvalid_o <= reg_rd_i;
      if (reg_rd_i) reg_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
  parameter int NUM_SRC  = 40,
  parameter int NUM_HART = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_rd,
  input logic                rvalid,
  input logic [NUM_HART-1:0] irq,
  input logic                dom_ie,
  input logic [NUM_HART-1:0] deliv,
  input logic [NUM_HART-1:0] top_nz,
  input logic [NUM_SRC-1:0]  src_off,
  input logic [NUM_SRC-1:0]  pend
);
  p_domain_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_ie |-> irq == '0);

  p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rvalid);

  p_read_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rvalid);

  for (genvar h = 0; h < NUM_HART; h++) begin : g_h
    p_deliv_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq[h] |-> deliv[h]);
    p_idle_low_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !top_nz[h] |-> !irq[h]);
  end

  for (genvar j = 0; j < NUM_SRC; j++) begin : g_s
    p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      src_off[j] |-> !pend[j]);
  end
endmodule

bind wired_irq_ctrl wic_checker #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART)) u_wic_chk (
  .clk(clk_i), .rst_n(rst_ni), .reg_rd(reg_rd_i), .rvalid(reg_rvalid_o), .irq(irq_o),
  .dom_ie(dom_ie_q), .deliv(deliv_q), .top_nz(top_nz), .src_off(src_off), .pend(pend)
);

// File: tb/wired_irq_ctrl_tb.sv
module wired_irq_ctrl_tb;
  localparam int NS = 40;
  localparam int NH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [NH-1:0] irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wired_irq_ctrl #(.NUM_SRC(NS), .NUM_HART(NH), .PRIO_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_irq_i(src), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .reg_rvalid_o(reg_rvalid), .irq_o(irq)
  );

  function automatic logic [15:0] cfg_a(int s); return 16'(16'h0004 + 4 * (s - 1)); endfunction
  function automatic logic [15:0] tgt_a(int s); return 16'(16'h2004 + 4 * (s - 1)); endfunction
  function automatic logic [15:0] idc_a(int h, int r); return 16'(16'h4000 + 32 * h + 4 * r); endfunction
  function automatic logic [31:0] cw(int s, int p); return 32'((s << 16) | p); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    chk("R10 rvalid", 32'(reg_rvalid), 32'd1);
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask
  task automatic drive(int s, logic v); @(negedge clk); src[s-1] = v; settle(); endtask

  task automatic setup_src(int s, int mode, int hart, int prio);
    wr(cfg_a(s), 32'(mode));
    wr(tgt_a(s), 32'((hart << 18) | prio));
    wr(16'h1080, 32'(s));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(16'h0000, d); chk("R1 domain", d, 0);
    chk("R1 irq", 32'(irq), 0);
    rd(idc_a(0, 3), d); chk("R1 claim", d, 0);
    rd(tgt_a(1), d); chk("R1 target", d, 0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    wr(cfg_a(1), 32'd7); rd(cfg_a(1), d); chk("R2 illegal mode", d, 0);
    wr(cfg_a(1), 32'd3); rd(cfg_a(1), d); chk("R2 mode readback", d, 3);
    wr(cfg_a(1), 32'd0); wr(16'h1080, 32'd1);
    drive(1, 1'b1); rd(idc_a(0, 2), d); chk("R2 inactive quiet", d, 0);
    drive(1, 1'b0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(16'h0000, 32'd1); wr(idc_a(0, 0), 32'd1); wr(idc_a(1, 0), 32'd1);
    setup_src(3, 1, 0, 2);
    drive(3, 1'b1);
    chk("R14 irq up", 32'(irq[0]), 1);
    rd(idc_a(0, 2), d); chk("R10 top", d, cw(3, 2));
    rd(idc_a(0, 3), d); chk("R3 rise claim", d, cw(3, 2));
    chk("R14 irq down", 32'(irq[0]), 0);
    rd(idc_a(0, 3), d); chk("R3 claim cleared", d, 0);
    src[3] = 1'b1; settle();
    setup_src(4, 2, 0, 2);
    rd(idc_a(0, 3), d); chk("R3 no fall yet", d, 0);
    drive(4, 1'b0);
    rd(idc_a(0, 3), d); chk("R3 fall claim", d, cw(4, 2));
    rd(idc_a(0, 3), d); chk("R3 fall cleared", d, 0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    drive(5, 1'b1);
    setup_src(5, 3, 0, 0); settle();
    rd(idc_a(0, 3), d); chk("R4 high claim", d, cw(5, 1));
    settle();
    rd(idc_a(0, 3), d); chk("R4 high repend", d, cw(5, 1));
    drive(5, 1'b0);
    rd(idc_a(0, 3), d); chk("R4 high gone", d, 0);
    setup_src(6, 4, 0, 0); settle();
    rd(idc_a(0, 3), d); chk("R4 low claim", d, cw(6, 1));
    drive(6, 1'b1);
    rd(idc_a(0, 3), d); chk("R4 low gone", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(cfg_a(7), 32'd1);
    drive(7, 1'b1);
    rd(idc_a(0, 2), d); chk("R5 disabled", d, 0);
    wr(16'h1080, 32'd0); wr(16'h1080, 32'd41);
    rd(idc_a(0, 2), d); chk("R5 bad numbers", d, 0);
    wr(16'h1080, 32'd7);
    rd(idc_a(0, 2), d); chk("R5 enabled prio0", d, cw(7, 1));
    wr(16'h1084, 32'd7);
    rd(idc_a(0, 2), d); chk("R5 cleared", d, 0);
    wr(16'h1080, 32'd7);
    rd(idc_a(0, 3), d); chk("R5 claim after re-enable", d, cw(7, 1));
  endtask

  task automatic t_bulk();
    logic [31:0] d;
    setup_src(2, 1, 0, 1); setup_src(33, 1, 0, 1);
    src[1] = 1'b1; src[32] = 1'b1; settle();
    wr(16'h1004, 32'hFFFF_FFFF);
    rd(idc_a(0, 3), d); chk("R6 word0 spared", d, cw(2, 1));
    rd(idc_a(0, 3), d); chk("R6 word1 cleared", d, 0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    setup_src(8, 1, 1, 1);
    drive(8, 1'b1);
    chk("R7 irq hart1", 32'(irq), 32'b10);
    rd(idc_a(0, 3), d); chk("R7 hart0 empty", d, 0);
    rd(idc_a(1, 3), d); chk("R7 hart1 claim", d, cw(8, 1));
  endtask

  task automatic t_prio();
    logic [31:0] d;
    setup_src(11, 1, 0, 3); setup_src(10, 1, 0, 1); setup_src(9, 1, 0, 0);
    @(negedge clk); src[8] = 1'b1; src[9] = 1'b1; src[10] = 1'b1; settle();
    rd(idc_a(0, 3), d); chk("R8 first tie", d, cw(9, 1));
    rd(idc_a(0, 3), d); chk("R8 second", d, cw(10, 1));
    rd(idc_a(0, 3), d); chk("R8 third", d, cw(11, 3));
    rd(idc_a(0, 3), d); chk("R14 empty", d, 0);
  endtask

  task automatic t_gates();
    logic [31:0] d;
    setup_src(12, 1, 0, 1);
    drive(12, 1'b1);
    chk("R14 line", 32'(irq[0]), 1);
    wr(16'h0000, 32'd0); chk("R11 ie off", 32'(irq), 0);
    wr(16'h0000, 32'd5); rd(16'h0000, d); chk("R11 msg bit", d, 1);
    chk("R11 ie on", 32'(irq[0]), 1);
    wr(idc_a(0, 0), 32'd0); chk("R12 deliv off", 32'(irq[0]), 0);
    rd(idc_a(0, 2), d); chk("R12 top kept", d, cw(12, 1));
    wr(idc_a(0, 0), 32'd1);
    wr(idc_a(0, 1), 32'd1); rd(idc_a(0, 2), d); chk("R9 thresh equal", d, 0);
    chk("R9 line off", 32'(irq[0]), 0);
    wr(idc_a(0, 1), 32'd2); rd(idc_a(0, 2), d); chk("R9 thresh above", d, cw(12, 1));
    wr(idc_a(0, 1), 32'd0);
    rd(idc_a(0, 3), d); chk("R10 claim", d, cw(12, 1));
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(16'h3000, d);      chk("R13 region", d, 0);
    rd(idc_a(3, 0), d);   chk("R13 hart", d, 0);
    rd(idc_a(0, 4), d);   chk("R13 offset", d, 0);
    rd(cfg_a(41), d);     chk("R13 source", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_edges();
    t_levels();
    t_enable();
    t_bulk();
    t_route();
    t_prio();
    t_gates();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule